// File: doc/BRIEF.md
# Sampling Converter Control Interface Model

This block models the digital side of a 16-bit sampling converter that has a parallel output. It lets host controller logic be exercised in simulation or on an FPGA without an analog part. The host drives an active-low select, an active-low convert strobe and an active-low read strobe. The model answers with a busy line and a data bus that has an explicit drive enable.

The conversion is a fixed delay counted in clock cycles. The sample on `sample_i` is captured on the clock edge that detects the start. The converted word appears in the output register only when the conversion finishes, and until then the register keeps showing the previous word. A start strobe that comes while a conversion runs has no effect.

The model also has a monitor for the convert strobe. It raises a flag when the strobe is released at a point where a real converter would lose accuracy: after a minimum low time, but before the conversion has finished. A host test can use this flag to catch a badly shaped strobe.

Top module: `adc_conv_if`

## Requirements
- R1: A conversion starts on the clock edge at which `convst_n_i` is sampled low after being sampled high, provided `cs_n_i` is low at that edge. If `cs_n_i` is high at that edge, nothing starts.
- R2: A falling convert strobe seen while a conversion is running changes neither the conversion length nor the result.
- R3: `busy_o` is low for exactly CONV_CYCLES clock cycles, starting in the cycle after the start edge. At all other times it is high.
- R4: `data_oe_o` is 1 exactly when `cs_n_i` and `rd_n_i` are both low. While it is 1, `data_o` equals the output register. While it is 0, `data_o` is all zeros, which stands for a released bus.
- R5: The output register holds its old value for the whole conversion. It loads the sample captured at the start edge on the same clock edge at which `busy_o` returns high.
- R6: When `rd_n_i` and `convst_n_i` are driven as one strobe with `cs_n_i` low, the strobe going low enables the bus at once with the previous result and also starts a conversion.
- R7: `window_viol_o` pulses high for one cycle, in the cycle after the edge at which the convert strobe is seen high again. It does so when the strobe's low time L (rise edge minus fall edge, in cycles) meets MIN_LOW_CYCLES <= L < CONV_CYCLES and the conversion is still running. For any other L it stays low.
- R8: While `rst_ni` is low and after it is released, `busy_o` is high, the output register is zero and `window_viol_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Select, active low |
| convst_n_i | input | 1 | Convert strobe; a falling edge starts a conversion |
| rd_n_i | input | 1 | Read strobe, active low |
| sample_i | input | DATA_W | Value to be converted |
| busy_o | output | 1 | Low while a conversion runs |
| data_o | output | DATA_W | Output register when enabled, otherwise zero |
| data_oe_o | output | 1 | Bus drive enable |
| window_viol_o | output | 1 | Pulse marking a strobe release inside the forbidden window |

## Verification
Two events can share a clock edge: the end of a conversion and the edge at which the convert strobe is seen high again. The bench sets this up with strobe low times of CONV_CYCLES-1 and CONV_CYCLES. The first must raise the window flag, and the second, where the release lands on the completion edge, must not. A second pairing is a read that is held open across the completion edge in the tied-strobe mode. The bench requires the bus to show the old word up to that edge and the new word from the cycle in which busy rises.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_LVL;
    else         prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
  assign rise_o = ~prev_q & sig_i;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_if_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20,
  parameter int CNT_W       = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] capt_o,
  output logic [DATA_W-1:0] result_o
);
  conv_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] capt_q, result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      capt_q   <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          cnt_q   <= CNT_W'(CONV_CYCLES - 1);
          capt_q  <= sample_i;
        end
        ST_CONV: begin
          // starts are not looked at here: mid-conversion requests drop
          if (cnt_q == '0) begin
            state_q  <= ST_IDLE;
            result_q <= capt_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (state_q == ST_CONV);
  assign cnt_o    = cnt_q;
  assign capt_o   = capt_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_window_mon.sv
module adc_window_mon #(
  parameter int CONV_CYCLES    = 20,
  parameter int MIN_LOW_CYCLES = 15,
  parameter int CNT_W          = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             viol_o
);
  logic viol_q, hit;
  int   low_len;

  // strobe low time at the rise edge, derived from the remaining count
  assign low_len = CONV_CYCLES - int'(cnt_i);
  assign hit     = rise_i && active_i && (cnt_i != '0) && (low_len >= MIN_LOW_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= hit;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/adc_conv_if.sv
module adc_conv_if #(
  parameter int DATA_W         = 16,
  parameter int CONV_CYCLES    = 20,
  parameter int MIN_LOW_CYCLES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              convst_n_i,
  input  logic              rd_n_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              window_viol_o
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic              conv_fall, conv_rise, conv_active;
  logic [CNT_W-1:0]  conv_cnt;
  logic [DATA_W-1:0] capt_q, result_q;

  adc_edge_det #(.IDLE_LVL(1'b1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (convst_n_i),
    .fall_o (conv_fall),
    .rise_o (conv_rise)
  );

  adc_conv_seq #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_fall & ~cs_n_i),
    .sample_i (sample_i),
    .active_o (conv_active),
    .cnt_o    (conv_cnt),
    .capt_o   (capt_q),
    .result_o (result_q)
  );

  adc_window_mon #(
    .CONV_CYCLES    (CONV_CYCLES),
    .MIN_LOW_CYCLES (MIN_LOW_CYCLES),
    .CNT_W          (CNT_W)
  ) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (conv_rise),
    .active_i (conv_active),
    .cnt_i    (conv_cnt),
    .viol_o   (window_viol_o)
  );

  assign busy_o    = ~conv_active;
  assign data_oe_o = ~cs_n_i & ~rd_n_i;
  assign data_o    = data_oe_o ? result_q : '0;
endmodule

// File: rtl/adc_conv_if_chk.sv
module adc_conv_if_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              conv_fall,
  input logic              busy_o,
  input logic              window_viol_o,
  input logic [DATA_W-1:0] capt_q,
  input logic [DATA_W-1:0] result_q
);
  int low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= 0;
    else if (!busy_o) low_cnt <= low_cnt + 1;
    else             low_cnt <= 0;
  end

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_fall && !cs_n_i && busy_o |=> !busy_o);

  p_cs_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i && busy_o |=> busy_o);

  p_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> low_cnt == CONV_CYCLES);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> (busy_o || $stable(result_q)));

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> result_q == $past(capt_q));

  p_flag_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_viol_o |-> $past(!busy_o));
endmodule

bind adc_conv_if adc_conv_if_chk #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_n_i        (cs_n_i),
  .conv_fall     (conv_fall),
  .busy_o        (busy_o),
  .window_viol_o (window_viol_o),
  .capt_q        (capt_q),
  .result_q      (result_q)
);

// File: tb/sim_adc_conv_if.sv
`timescale 1ns/1ps
module sim_adc_conv_if;
  localparam int C   = 20;
  localparam int MIN = 15;

  typedef struct packed {
    logic        cs_n;
    logic [15:0] val;
    logic [7:0]  low;
    logic        exp_start;
    logic        exp_viol;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b0, 16'h1234, 8'd2,  1'b1, 1'b0},
    '{1'b1, 16'hBEEF, 8'd2,  1'b0, 1'b0},
    '{1'b0, 16'hFFFF, 8'd14, 1'b1, 1'b0},
    '{1'b0, 16'h0001, 8'd15, 1'b1, 1'b1},
    '{1'b0, 16'h8000, 8'd19, 1'b1, 1'b1},
    '{1'b0, 16'hA5A5, 8'd20, 1'b1, 1'b0},
    '{1'b0, 16'h5A5A, 8'd25, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, convst_n = 1'b1, rd_n = 1'b1;
  logic [15:0] sample = '0;
  logic busy, oe, viol;
  logic [15:0] data;

  int n_cmp = 0, n_err = 0, cyc = 0;
  int busy_low, viol_seen;
  logic [15:0] exp_data = '0;

  always #10 clk = ~clk;

  adc_conv_if #(.DATA_W(16), .CONV_CYCLES(C), .MIN_LOW_CYCLES(MIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .convst_n_i(convst_n),
    .rd_n_i(rd_n), .sample_i(sample), .busy_o(busy), .data_o(data),
    .data_oe_o(oe), .window_viol_o(viol)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    if (!busy) busy_low++;
    if (viol)  viol_seen++;
  endtask

  task automatic read_check(input string req, input logic [15:0] exp);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk({req, " oe"}, 32'(oe), 1);
    chk({req, " data"}, 32'(data), 32'(exp));
    rd_n = 1'b1; #1;
    chk("R4 oe off", 32'(oe), 0);
    chk("R4 data zero", 32'(data), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; #1;
    chk("R8 busy", 32'(busy), 1);
    chk("R8 flag", 32'(viol), 0);
    chk("R4 oe idle", 32'(oe), 0);
    read_check("R8 result", 16'h0000);
    cs_n = 1'b1;
    tick();

    foreach (VECS[i]) begin
      busy_low = 0; viol_seen = 0;
      cs_n = VECS[i].cs_n; sample = VECS[i].val; convst_n = 1'b0;
      tick();
      chk("R1 start", 32'(busy), VECS[i].exp_start ? 0 : 1);
      sample = ~VECS[i].val;
      for (int k = 1; k < int'(VECS[i].low); k++) tick();
      convst_n = 1'b1;
      tick();
      for (int k = 0; k < 60 && !busy; k++) tick();
      chk("R3 busy length", busy_low, VECS[i].exp_start ? C : 0);
      chk("R7 window flag", viol_seen, VECS[i].exp_viol ? 1 : 0);
      if (VECS[i].exp_start) exp_data = VECS[i].val;
      read_check("R5 result", exp_data);
      cs_n = 1'b1;
      tick();
    end

    // R2: second fall mid-conversion
    busy_low = 0; viol_seen = 0;
    cs_n = 1'b0; sample = 16'h1111; convst_n = 1'b0;
    tick();
    sample = 16'h2222;
    repeat (4) tick();
    convst_n = 1'b1; tick();
    repeat (2) tick();
    convst_n = 1'b0; tick();
    convst_n = 1'b1;
    for (int k = 0; k < 60 && !busy; k++) tick();
    chk("R2 length unchanged", busy_low, C);
    chk("R2 no flag", viol_seen, 0);
    exp_data = 16'h1111;
    read_check("R2 result", exp_data);
    busy_low = 0;
    repeat (3) tick();
    chk("R2 no late start", busy_low, 0);

    // R6: read and convert tied, held until busy returns
    begin
      int old_ok = 1;
      busy_low = 0; viol_seen = 0;
      sample = 16'h3C3C; cs_n = 1'b0;
      rd_n = 1'b0; convst_n = 1'b0; #1;
      chk("R6 oe on strobe", 32'(oe), 1);
      chk("R6 previous data", 32'(data), 32'(exp_data));
      tick();
      chk("R6 started", 32'(busy), 0);
      sample = 16'h0F0F;
      while (!busy && busy_low < 60) begin
        if (data !== exp_data) old_ok = 0;
        tick();
      end
      chk("R5 old word while busy", old_ok, 1);
      chk("R5 new word at busy rise", 32'(data), 32'h3C3C);
      chk("R3 tied length", busy_low, C);
      rd_n = 1'b1; convst_n = 1'b1;
      tick();
      chk("R7 tied no flag", viol_seen, 0);
    end

    summary();
  end
endmodule